// File: doc/BRIEF.md
# Hold and Low-Power Mode Controller

This block decides when a small controller leaves normal operation for one of two halt states and when it comes back. A Clock Stop halt turns off both the oscillator and the CPU clock, forces the display and CMOS port drivers low, and releases the open-drain outputs. A Wait halt keeps the oscillator running and only suspends the CPU. Wait has two variants. In the oscillator-only variant the display is also forced low. In the CPU-suspend variant every pin keeps its state. The oscillator and the CPU are outside this block and appear here only as enable outputs.

A halt starts from a one-cycle instruction strobe. A stop strobe can be made conditional: it then takes effect only while the HOLD pin reads low. It can also be made unconditional. A wait strobe always takes effect. The HOLD pin is asynchronous and passes through a synchroniser on the always-on clock. Clock Stop ends either when HOLD reads high or when HOLD differs from its value at entry, chosen by a configuration bit. Wait ends whenever HOLD differs from its value at entry. On every return to normal operation the block emits a one-cycle wake pulse. After a Clock Stop exit it keeps the CPU clock off for a programmable number of cycles so that the oscillator can settle. All pins are plain control levels; no data stream passes through the block, so it has no valid/ready handshake.

Top module: `hold_pwr_ctrl`

## Requirements
- R1: After reset the mode output is 0 (run), osc_en and cpu_clk_en are 1, and disp_force_low, cmos_force_low, od_release and wake_pulse are 0.
- R2: A ckstp_stb accepted in run mode enters mode 1 (clock stop) on the next edge when cfg_stop_forced is 1, whatever HOLD reads. When cfg_stop_forced is 0 it enters only if the synchronised HOLD is low; otherwise it is ignored, the mode stays 0 and cpu_clk_en stays 1.
- R3: In mode 1, osc_en and cpu_clk_en are 0 and disp_force_low, cmos_force_low and od_release are 1.
- R4: Mode 1 is left, back to mode 0, under one of two rules. With cfg_wake_any at 0 it is left when the synchronised HOLD is high. With cfg_wake_any at 1 it is left when the synchronised HOLD differs from its value at entry. An unchanged HOLD keeps the block stopped. A pin change takes effect on the third rising edge after it: two synchroniser flops, then the mode register.
- R5: A wait_stb accepted in run mode enters a wait mode on the next edge, whatever HOLD reads. The mode is 2 (oscillator-only) when cfg_wait_osc is 1 and 3 (CPU-suspend) when it is 0.
- R6: In mode 2, osc_en is 1, cpu_clk_en is 0, disp_force_low is 1, and cmos_force_low and od_release are 0. In mode 3, osc_en is 1 and cpu_clk_en, disp_force_low, cmos_force_low and od_release are all 0.
- R7: A wait mode is left, back to mode 0, only when the synchronised HOLD differs from its value at entry. The level HOLD holds, whether high or low, releases nothing, and the release follows the same three-edge latency as R4.
- R8: Every exit to mode 0 raises wake_pulse for exactly the first run cycle. wake_pulse is 0 at all other times.
- R9: After a clock stop exit, osc_en is 1 at once, and cpu_clk_en stays 0 for cfg_settle cycles before rising. After a wait exit, cpu_clk_en is 1 in the first run cycle.
- R10: Strobes are accepted only in mode 0 with cpu_clk_en at 1. They are ignored in every halt mode and during the settle window. When both strobes arrive together, an accepted stop entry wins; if the stop entry is refused, the wait entry is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_pin | input | 1 | Asynchronous HOLD pin level |
| ckstp_stb | input | 1 | One-cycle clock-stop instruction strobe |
| wait_stb | input | 1 | One-cycle wait instruction strobe |
| cfg_stop_forced | input | 1 | 1: stop strobe enters unconditionally; 0: only while HOLD is low |
| cfg_wake_any | input | 1 | 1: clock stop ends on any HOLD change; 0: on HOLD high |
| cfg_wait_osc | input | 1 | 1: wait keeps only the oscillator and forces the display low; 0: CPU-suspend |
| cfg_settle | input | SETTLE_W | Oscillator settle time after a clock stop exit, in cycles |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| disp_force_low | output | 1 | Force display outputs low |
| cmos_force_low | output | 1 | Force CMOS port outputs low |
| od_release | output | 1 | Turn open-drain outputs off |
| wake_pulse | output | 1 | One-cycle pulse on each return to run |
| mode | output | 2 | Current mode: 0 run, 1 clock stop, 2 wait oscillator-only, 3 wait CPU-suspend |

## Verification
Two situations are the hardest to reach from the pins.

The first is a strobe that arrives during the post-stop settle window. The stimulus reaches it by pulsing a forced stop strobe in the first settle cycle of every sweep case with a settle time of two or more, then checking that the mode stays at run.

The second is a forced stop entered while HOLD is already high under the level wake rule. The block must stay stopped for exactly one cycle and still settle. The sweep covers every combination of forced entry, wake rule, HOLD level at entry and settle time, and computes from those four values whether entry happens, whether the exit is immediate and at which negedge cpu_clk_en returns.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN      = 2'd0,
    MODE_STOP     = 2'd1,
    MODE_WAIT_OSC = 2'd2,
    MODE_WAIT_CPU = 2'd3
  } hpc_mode_e;
endpackage

// File: rtl/hpc_sync.sv
module hpc_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hpc_settle.sv
module hpc_settle #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R9: a non-zero load always opens a busy window on the next cycle
  a_r9_load_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> busy);
endmodule

// File: rtl/hpc_fsm.sv
module hpc_fsm
  import hpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hold_s,
  input  logic      ckstp_stb,
  input  logic      wait_stb,
  input  logic      accept,
  input  logic      cfg_stop_forced,
  input  logic      cfg_wake_any,
  input  logic      cfg_wait_osc,
  output hpc_mode_e mode,
  output logic      stop_exit,
  output logic      wake_pulse
);
  hpc_mode_e mode_q, mode_n;
  logic      ref_q, ref_n;
  logic      exit_n;
  logic      stop_ok;
  logic      stop_rel;

  assign stop_ok  = cfg_stop_forced || !hold_s;
  assign stop_rel = cfg_wake_any ? (hold_s != ref_q) : hold_s;

  always_comb begin
    mode_n = mode_q;
    ref_n  = ref_q;
    exit_n = 1'b0;
    case (mode_q)
      MODE_RUN: begin
        if (accept) begin
          if (ckstp_stb && stop_ok) begin
            mode_n = MODE_STOP;
            ref_n  = hold_s;
          end else if (wait_stb) begin
            mode_n = cfg_wait_osc ? MODE_WAIT_OSC : MODE_WAIT_CPU;
            ref_n  = hold_s;
          end
        end
      end
      MODE_STOP: begin
        if (stop_rel) begin
          mode_n = MODE_RUN;
          exit_n = 1'b1;
        end
      end
      MODE_WAIT_OSC, MODE_WAIT_CPU: begin
        if (hold_s != ref_q) begin
          mode_n = MODE_RUN;
          exit_n = 1'b1;
        end
      end
      default: mode_n = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_RUN;
      ref_q      <= 1'b1;
      wake_pulse <= 1'b0;
    end else begin
      mode_q     <= mode_n;
      ref_q      <= ref_n;
      wake_pulse <= exit_n;
    end
  end

  assign mode      = mode_q;
  assign stop_exit = exit_n && (mode_q == MODE_STOP);

  // R8: the wake pulse lasts one cycle
  a_r8_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  // R8: the wake pulse appears only in the first run cycle after a halt
  a_r8_wake_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (mode_q == MODE_RUN && $past(mode_q) != MODE_RUN));

  // R2: a conditional stop entry needs HOLD low
  a_r2_stop_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == MODE_RUN && mode_q == MODE_STOP && !$past(cfg_stop_forced))
      |-> !$past(hold_s));

  // R10: no halt starts without a strobe
  a_r10_halt_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == MODE_RUN && mode_q != MODE_RUN)
      |-> $past(ckstp_stb || wait_stb));

  // R5: a wait entry comes from the wait strobe
  a_r5_wait_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == MODE_RUN && (mode_q == MODE_WAIT_OSC || mode_q == MODE_WAIT_CPU))
      |-> $past(wait_stb));
endmodule

// File: rtl/hold_pwr_ctrl.sv
module hold_pwr_ctrl
  import hpc_pkg::*;
#(
  parameter int SETTLE_W    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_aon,
  input  logic                rst_n,
  input  logic                hold_pin,
  input  logic                ckstp_stb,
  input  logic                wait_stb,
  input  logic                cfg_stop_forced,
  input  logic                cfg_wake_any,
  input  logic                cfg_wait_osc,
  input  logic [SETTLE_W-1:0] cfg_settle,
  output logic                osc_en,
  output logic                cpu_clk_en,
  output logic                disp_force_low,
  output logic                cmos_force_low,
  output logic                od_release,
  output logic                wake_pulse,
  output logic [1:0]          mode
);
  logic      hold_s;
  logic      settling;
  logic      stop_exit;
  logic      accept;
  hpc_mode_e cur_mode;

  hpc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk     (clk_aon),
    .rst_n   (rst_n),
    .d_async (hold_pin),
    .q       (hold_s)
  );

  hpc_settle #(.CW(SETTLE_W)) u_settle (
    .clk      (clk_aon),
    .rst_n    (rst_n),
    .load     (stop_exit),
    .load_val (cfg_settle),
    .busy     (settling)
  );

  hpc_fsm u_fsm (
    .clk             (clk_aon),
    .rst_n           (rst_n),
    .hold_s          (hold_s),
    .ckstp_stb       (ckstp_stb),
    .wait_stb        (wait_stb),
    .accept          (accept),
    .cfg_stop_forced (cfg_stop_forced),
    .cfg_wake_any    (cfg_wake_any),
    .cfg_wait_osc    (cfg_wait_osc),
    .mode            (cur_mode),
    .stop_exit       (stop_exit),
    .wake_pulse      (wake_pulse)
  );

  assign accept         = (cur_mode == MODE_RUN) && !settling;
  assign cpu_clk_en     = accept;
  assign osc_en         = (cur_mode != MODE_STOP);
  assign disp_force_low = (cur_mode == MODE_STOP) || (cur_mode == MODE_WAIT_OSC);
  assign cmos_force_low = (cur_mode == MODE_STOP);
  assign od_release     = (cur_mode == MODE_STOP);
  assign mode           = cur_mode;

  // R9: the CPU clock stays off in the first run cycle after a stop with a non-zero settle time
  a_r9_settle_blocks_cpu: assert property (@(posedge clk_aon) disable iff (!rst_n)
    ($past(cur_mode) == MODE_STOP && cur_mode == MODE_RUN && $past(cfg_settle) != '0)
      |-> !cpu_clk_en);

  // R9: a wait exit restores the CPU clock at once
  a_r9_wait_fast_cpu: assert property (@(posedge clk_aon) disable iff (!rst_n)
    (($past(cur_mode) == MODE_WAIT_OSC || $past(cur_mode) == MODE_WAIT_CPU)
      && cur_mode == MODE_RUN) |-> cpu_clk_en);
endmodule

// File: tb/hold_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module hold_pwr_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hold_pin = 1'b1;
  logic       ckstp_stb = 1'b0;
  logic       wait_stb = 1'b0;
  logic       cfg_stop_forced = 1'b0;
  logic       cfg_wake_any = 1'b0;
  logic       cfg_wait_osc = 1'b0;
  logic [3:0] cfg_settle = 4'd0;
  logic       osc_en, cpu_clk_en, disp_force_low, cmos_force_low, od_release, wake_pulse;
  logic [1:0] mode;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  hold_pwr_ctrl #(.SETTLE_W(4), .SYNC_STAGES(2)) dut_i (
    .clk_aon         (clk),
    .rst_n           (rst_n),
    .hold_pin        (hold_pin),
    .ckstp_stb       (ckstp_stb),
    .wait_stb        (wait_stb),
    .cfg_stop_forced (cfg_stop_forced),
    .cfg_wake_any    (cfg_wake_any),
    .cfg_wait_osc    (cfg_wait_osc),
    .cfg_settle      (cfg_settle),
    .osc_en          (osc_en),
    .cpu_clk_en      (cpu_clk_en),
    .disp_force_low  (disp_force_low),
    .cmos_force_low  (cmos_force_low),
    .od_release      (od_release),
    .wake_pulse      (wake_pulse),
    .mode            (mode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic run_stop(input bit f, input bit w, input bit h, input int s);
    cfg_stop_forced = f;
    cfg_wake_any    = w;
    cfg_settle      = 4'(s);
    hold_pin        = h;
    repeat (4) @(negedge clk);
    ckstp_stb = 1'b1;
    @(negedge clk);
    ckstp_stb = 1'b0;
    if (!(f || !h)) begin
      chk("R2 refused stop keeps run", int'(mode), 0);
      chk("R2 refused stop keeps cpu", int'(cpu_clk_en), 1);
      return;
    end
    chk("R2 stop entered", int'(mode), 1);
    chk("R3 osc off", int'(osc_en), 0);
    chk("R3 cpu off", int'(cpu_clk_en), 0);
    chk("R3 disp low", int'(disp_force_low), 1);
    chk("R3 cmos low", int'(cmos_force_low), 1);
    chk("R3 od released", int'(od_release), 1);
    if (!w && h) begin
      @(negedge clk);
    end else begin
      repeat (3) @(negedge clk);
      chk("R4 unchanged hold stays stopped", int'(mode), 1);
      hold_pin = !h;
      repeat (2) @(negedge clk);
      chk("R4 two edges still stopped", int'(mode), 1);
      @(negedge clk);
    end
    chk("R4 released to run", int'(mode), 0);
    chk("R8 wake pulse on exit", int'(wake_pulse), 1);
    chk("R9 osc on at exit", int'(osc_en), 1);
    for (int i = 0; i <= s; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 1 && s >= 2) begin
        ckstp_stb = 1'b0;
        cfg_stop_forced = f;
        chk("R10 strobe ignored while settling", int'(mode), 0);
      end
      chk("R9 cpu settle window", int'(cpu_clk_en), (i >= s) ? 1 : 0);
      if (i == 0 && s >= 2) begin
        cfg_stop_forced = 1'b1;
        ckstp_stb = 1'b1;
      end
    end
    @(negedge clk);
    chk("R8 wake pulse one cycle", int'(wake_pulse), 0);
  endtask

  task automatic run_wait(input bit o, input bit h);
    cfg_wait_osc = o;
    hold_pin     = h;
    repeat (4) @(negedge clk);
    wait_stb = 1'b1;
    @(negedge clk);
    wait_stb = 1'b0;
    chk("R5 wait mode", int'(mode), o ? 2 : 3);
    chk("R6 osc on", int'(osc_en), 1);
    chk("R6 cpu off", int'(cpu_clk_en), 0);
    chk("R6 disp", int'(disp_force_low), o ? 1 : 0);
    chk("R6 cmos", int'(cmos_force_low), 0);
    chk("R6 od", int'(od_release), 0);
    repeat (3) @(negedge clk);
    chk("R7 level does not release", int'(mode), o ? 2 : 3);
    cfg_stop_forced = 1'b1;
    ckstp_stb = 1'b1;
    @(negedge clk);
    ckstp_stb = 1'b0;
    cfg_stop_forced = 1'b0;
    chk("R10 strobe ignored in wait", int'(mode), o ? 2 : 3);
    hold_pin = !h;
    repeat (2) @(negedge clk);
    chk("R7 two edges still waiting", int'(mode), o ? 2 : 3);
    @(negedge clk);
    chk("R7 released to run", int'(mode), 0);
    chk("R8 wake on wait exit", int'(wake_pulse), 1);
    chk("R9 cpu at once after wait", int'(cpu_clk_en), 1);
    @(negedge clk);
    chk("R8 wake pulse one cycle", int'(wake_pulse), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode", int'(mode), 0);
    chk("R1 osc", int'(osc_en), 1);
    chk("R1 cpu", int'(cpu_clk_en), 1);
    chk("R1 disp", int'(disp_force_low), 0);
    chk("R1 cmos", int'(cmos_force_low), 0);
    chk("R1 od", int'(od_release), 0);
    chk("R1 wake", int'(wake_pulse), 0);

    for (int f = 0; f < 2; f++)
      for (int w = 0; w < 2; w++)
        for (int h = 0; h < 2; h++)
          for (int s = 0; s < 4; s++)
            run_stop(f[0], w[0], h[0], s);

    cfg_stop_forced = 1'b0;
    for (int o = 0; o < 2; o++)
      for (int h = 0; h < 2; h++)
        run_wait(o[0], h[0]);

    // R10: both strobes together, stop entry accepted
    cfg_settle = 4'd0; cfg_wake_any = 1'b1; cfg_stop_forced = 1'b1; hold_pin = 1'b1;
    repeat (4) @(negedge clk);
    ckstp_stb = 1'b1; wait_stb = 1'b1;
    @(negedge clk);
    ckstp_stb = 1'b0; wait_stb = 1'b0;
    chk("R10 stop wins over wait", int'(mode), 1);
    hold_pin = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 change release", int'(mode), 0);

    // R10: both strobes together, stop refused so wait is taken
    cfg_stop_forced = 1'b0; cfg_wait_osc = 1'b0; hold_pin = 1'b1;
    repeat (4) @(negedge clk);
    ckstp_stb = 1'b1; wait_stb = 1'b1;
    @(negedge clk);
    ckstp_stb = 1'b0; wait_stb = 1'b0;
    chk("R10 refused stop falls to wait", int'(mode), 3);
    hold_pin = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 change release", int'(mode), 0);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
    end
  end
endmodule